// File: doc/BRIEF.md
# Buck-Boost Operating Mode Selector

This block chooses, once per switching period, how a four-switch non-inverting buck-boost power stage is driven. It times the first switch phase of every period in system clocks, compares that count against a long and a short threshold, and steps between five modes: off, buck, a transition mode entered from buck, boost, and a transition mode entered from boost. The long threshold is set near 16 % of the period. The short threshold is set a little under half the long one, so that the buck/boost boundary has hysteresis.

The analog side supplies two single-clock strobes. One marks the start of each switching period. The other marks the end of the first phase of that period. A run input enables the converter. A soft-start-done flag keeps the machine in buck until the output has ramped. Software-facing thresholds arrive as plain inputs. The block returns a mode code and two select lines that steer the current-loop polarity. The select lines also depend on the run input directly, so they form a Mealy output.

Top module: `bb_mode_fsm`

## Requirements
- R1: While reset is asserted and after its release with run low, mode_o is 3'b000 and buck_o and boost_o are low.
- R2: mode_o carries the state with the codes off=3'b000, buck=3'b001, buck-transition=3'b011, boost=3'b010 and boost-transition=3'b110, and it never takes any other value.
- R3: With run high, mode_o changes only at a clock edge where cycle_start_i is high, and the new mode shows right after that edge; a mode therefore lasts at least one whole period.
- R4: The duty of a period is the number of clocks from the edge that samples cycle_start_i to the edge that first samples phase_end_i. If no phase end arrives, the duty equals the full period length. A decision at a cycle start always uses the duty of the period that just ended.
- R5: From off, the first cycle start with run high enters buck, whatever the duty.
- R6: In buck with ss_done_i high, a duty below long_th_i leads to buck-transition. While ss_done_i is low, buck holds.
- R7: In buck-transition, a duty below short_th_i leads to boost, a duty at or above long_th_i returns to buck, and any other duty holds.
- R8: In boost, a duty below long_th_i leads to boost-transition, and otherwise boost holds. Buck never goes straight to boost, and boost never goes straight to buck.
- R9: In boost-transition, a duty below short_th_i leads to buck, a duty at or above long_th_i returns to boost, and any other duty holds.
- R10: run_i low at a clock edge puts the machine in off after that edge, from any state.
- R11: buck_o is high exactly when run_i is high and the state is buck or buck-transition. boost_o is high exactly when run_i is high and the state is boost or boost-transition. Both outputs fall in the same cycle that run_i falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | Converter enable |
| ss_done_i | input | 1 | Soft start finished |
| cycle_start_i | input | 1 | One-clock strobe at the start of each switching period |
| phase_end_i | input | 1 | One-clock strobe at the end of the first switch phase |
| long_th_i | input | CNT_W | Long duty threshold in clocks |
| short_th_i | input | CNT_W | Short duty threshold in clocks |
| mode_o | output | 3 | Current mode code |
| buck_o | output | 1 | Buck-side current loop select |
| boost_o | output | 1 | Boost-side current loop select |

## Verification
The stimulus is a run of 125-clock periods. Each period is given a chosen first-phase length, so the duty falls below the short threshold, between the two thresholds, exactly on either threshold, or has no phase end at all. Exact-threshold duties separate a strict comparison from an inclusive one. In-between duties show that each transition mode holds rather than drifting. The no-end period shows that a missing strobe counts as full duty. Short duties given while soft start is pending show the buck lock. The run input is then dropped in boost, first to observe that the select lines fall before the state changes, and then to observe that the restart goes through buck.

// File: rtl/bbm_pkg.sv
`timescale 1ns/1ps
package bbm_pkg;

  typedef enum logic [2:0] {
    MODE_OFF      = 3'b000,
    MODE_BUCK     = 3'b001,
    MODE_BUCK_TR  = 3'b011,
    MODE_BOOST    = 3'b010,
    MODE_BOOST_TR = 3'b110
  } mode_e;

  // Next mode at a period boundary, given the duty comparisons of the
  // period that just ended.
  function automatic mode_e bbm_decide(mode_e cur, logic ss_done,
                                       logic below_long, logic below_short);
    mode_e nxt;
    case (cur)
      MODE_OFF:      nxt = MODE_BUCK;
      MODE_BUCK:     nxt = (ss_done && below_long) ? MODE_BUCK_TR : MODE_BUCK;
      MODE_BUCK_TR:  nxt = below_short ? MODE_BOOST :
                           (!below_long ? MODE_BUCK : MODE_BUCK_TR);
      MODE_BOOST:    nxt = below_long ? MODE_BOOST_TR : MODE_BOOST;
      MODE_BOOST_TR: nxt = below_short ? MODE_BUCK :
                           (!below_long ? MODE_BOOST : MODE_BOOST_TR);
      default:       nxt = MODE_OFF;
    endcase
    return nxt;
  endfunction

  function automatic logic bbm_is_buck_side(mode_e m);
    return (m == MODE_BUCK) || (m == MODE_BUCK_TR);
  endfunction

  function automatic logic bbm_is_boost_side(mode_e m);
    return (m == MODE_BOOST) || (m == MODE_BOOST_TR);
  endfunction

endpackage

// File: rtl/bbm_duty_meter.sv
`timescale 1ns/1ps
module bbm_duty_meter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cycle_start_i,
  input  logic             phase_end_i,
  input  logic [CNT_W-1:0] long_th_i,
  input  logic [CNT_W-1:0] short_th_i,
  output logic             below_long_o,
  output logic             below_short_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] duty_q;
  logic             seen_q;
  logic [CNT_W-1:0] duty_w;
  logic             capture_w;

  // Only the first phase end of a period is kept.
  assign capture_w = phase_end_i && !cycle_start_i && !seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      duty_q <= '0;
      seen_q <= 1'b0;
    end else if (cycle_start_i) begin
      cnt_q  <= CNT_ONE;
      seen_q <= 1'b0;
    end else begin
      if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
      if (capture_w) begin
        seen_q <= 1'b1;
        duty_q <= cnt_q;
      end
    end
  end

  // A period without a phase end counts as full duty.
  assign duty_w        = seen_q ? duty_q : cnt_q;
  assign below_long_o  = duty_w < long_th_i;
  assign below_short_o = duty_w < short_th_i;

  // R4
  duty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && !cycle_start_i |=> $stable(duty_q));

  // R4
  duty_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cycle_start_i |=> !seen_q);

endmodule

// File: rtl/bbm_next_state.sv
`timescale 1ns/1ps
module bbm_next_state
  import bbm_pkg::*;
(
  input  mode_e cur_i,
  input  logic  run_i,
  input  logic  step_i,
  input  logic  ss_done_i,
  input  logic  below_long_i,
  input  logic  below_short_i,
  output mode_e nxt_o
);

  always_comb begin
    if (!run_i)
      nxt_o = MODE_OFF;
    else if (step_i)
      nxt_o = bbm_decide(cur_i, ss_done_i, below_long_i, below_short_i);
    else
      nxt_o = cur_i;
  end

endmodule

// File: rtl/bb_mode_fsm.sv
`timescale 1ns/1ps
module bb_mode_fsm
  import bbm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             ss_done_i,
  input  logic             cycle_start_i,
  input  logic             phase_end_i,
  input  logic [CNT_W-1:0] long_th_i,
  input  logic [CNT_W-1:0] short_th_i,
  output logic [2:0]       mode_o,
  output logic             buck_o,
  output logic             boost_o
);

  mode_e state_q;
  mode_e next_w;
  logic  below_long_w;
  logic  below_short_w;

  bbm_duty_meter #(.CNT_W(CNT_W)) u_meter (
    .clk           (clk),
    .rst_n         (rst_n),
    .cycle_start_i (cycle_start_i),
    .phase_end_i   (phase_end_i),
    .long_th_i     (long_th_i),
    .short_th_i    (short_th_i),
    .below_long_o  (below_long_w),
    .below_short_o (below_short_w)
  );

  bbm_next_state u_next (
    .cur_i         (state_q),
    .run_i         (run_i),
    .step_i        (cycle_start_i),
    .ss_done_i     (ss_done_i),
    .below_long_i  (below_long_w),
    .below_short_i (below_short_w),
    .nxt_o         (next_w)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= MODE_OFF;
    else        state_q <= next_w;
  end

  assign mode_o  = state_q;
  assign buck_o  = run_i && bbm_is_buck_side(state_q);
  assign boost_o = run_i && bbm_is_boost_side(state_q);

  // R10
  run_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> mode_o == 3'b000);

  // R3
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_i && !cycle_start_i |=> $stable(mode_o));

  // R2
  legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o inside {3'b000, 3'b001, 3'b011, 3'b010, 3'b110});

  // R11
  sel_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({buck_o, boost_o}));

  // R5
  start_buck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 3'b000 && run_i && cycle_start_i |=> mode_o == 3'b001);

  // R8
  no_buck_to_boost_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 3'b001 |=> mode_o != 3'b010);

  // R8
  no_boost_to_buck_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mode_o == 3'b010 |=> mode_o != 3'b001);

endmodule

// File: tb/bb_mode_fsm_bench.sv
`timescale 1ns/1ps
module bb_mode_fsm_bench;

  localparam int W     = 8;
  localparam int PER   = 125;
  localparam int LONG  = 20;
  localparam int SHORT = 9;

  localparam logic [2:0] C_OFF = 3'b000, C_BK = 3'b001, C_BKT = 3'b011,
                         C_BS = 3'b010, C_BST = 3'b110;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, ssd = 1'b0, cs = 1'b0, pe = 1'b0;
  logic [W-1:0] lth = W'(LONG);
  logic [W-1:0] sth = W'(SHORT);
  logic [2:0] mode;
  logic buck, boost;

  always #10 clk = ~clk;

  bb_mode_fsm #(.CNT_W(W)) u_bb_mode_fsm (
    .clk(clk), .rst_n(rst_n), .run_i(run), .ss_done_i(ssd),
    .cycle_start_i(cs), .phase_end_i(pe), .long_th_i(lth), .short_th_i(sth),
    .mode_o(mode), .buck_o(buck), .boost_o(boost)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [2:0] exp_q[$];
  string tag_q[$];
  logic [2:0] m = C_OFF;
  int prev_d = 0;

  task automatic check(bit ok, string req, int act, int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic summary();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Reference model written from the requirement text
  function automatic logic [2:0] model_next(logic [2:0] s, int d);
    if (s == C_OFF) return C_BK;
    if (s == C_BK)  return (ssd && d < LONG) ? C_BKT : C_BK;
    if (s == C_BKT) begin
      if (d < SHORT) return C_BS;
      if (d >= LONG) return C_BK;
      return C_BKT;
    end
    if (s == C_BS)  return (d < LONG) ? C_BST : C_BS;
    if (d < SHORT) return C_BK;
    if (d >= LONG) return C_BS;
    return C_BST;
  endfunction

  // Driver: one switching period whose first phase lasts d clocks
  // (d >= PER means no phase end). Entered just after a negedge.
  task automatic cyc(int d, string req);
    cs = 1'b1;
    @(posedge clk); #1;
    m = model_next(m, prev_d);
    prev_d = (d < PER) ? d : PER;
    exp_q.push_back(m);
    tag_q.push_back(req);
    @(negedge clk); cs = 1'b0;
    if (d < PER) begin
      repeat (d - 1) @(negedge clk);
      pe = 1'b1;
      @(negedge clk); pe = 1'b0;
      repeat (PER - d - 1) @(negedge clk);
    end else begin
      repeat (PER - 1) @(negedge clk);
    end
    check(mode == m, "R3 mode held to end of period", mode, m);
  endtask

  // Monitor: compare results after each period boundary
  initial begin
    forever begin
      @(negedge clk);
      if (exp_q.size() > 0) begin
        logic [2:0] e;
        string r;
        e = exp_q.pop_front();
        r = tag_q.pop_front();
        check(mode == e, r, mode, e);
        check(buck == (e == C_BK || e == C_BKT), "R11 buck select", buck, 0);
        check(boost == (e == C_BS || e == C_BST), "R11 boost select", boost, 0);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mode == C_OFF, "R1 reset mode", mode, C_OFF);
    check(!buck && !boost, "R1 selects low in reset", {buck, boost}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(mode == C_OFF, "R1 off after reset with run low", mode, C_OFF);
    run = 1'b1;
    cyc(50, "R5 off to buck");
    cyc(10, "R6 buck holds on long duty");
    cyc(10, "R6 soft start pending holds buck");
    ssd = 1'b1;
    cyc(50, "R6 buck to buck-transition");
    cyc(15, "R7 long duty returns to buck");
    cyc(15, "R6 buck to buck-transition again");
    cyc(5,  "R7 mid duty holds buck-transition");
    cyc(30, "R7 short duty enters boost");
    cyc(40, "R8 boost held for a full period");
    cyc(12, "R8 boost holds on long duty");
    cyc(8,  "R8 boost to boost-transition");
    cyc(12, "R9 short duty back to buck");
    cyc(9,  "R6 buck to buck-transition");
    cyc(20, "R7 duty equal to short threshold holds");
    cyc(19, "R7 duty equal to long threshold returns to buck");
    cyc(5,  "R6 buck to buck-transition");
    cyc(PER, "R7 enter boost");
    cyc(3,  "R4 missing phase end counts as full duty");
    cyc(10, "R8 boost to boost-transition");
    cyc(60, "R9 mid duty holds boost-transition");
    cyc(60, "R9 long duty returns to boost");
    repeat (2) @(negedge clk);
    run = 1'b0;
    #1;
    check(!buck && !boost, "R11 selects fall with run", {buck, boost}, 0);
    check(mode == C_BS, "R11 state not yet changed", mode, C_BS);
    @(negedge clk);
    check(mode == C_OFF, "R10 run low forces off", mode, C_OFF);
    repeat (5) @(negedge clk);
    check(mode == C_OFF, "R10 off holds", mode, C_OFF);
    run = 1'b1;
    m = C_OFF;
    cyc(4,  "R5 restart enters buck");
    cyc(50, "R6 short duty moves to buck-transition");
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      summary();
      $finish;
    end
  end

endmodule